// File: doc/BRIEF.md
# Rotated Immediate Encoder with Opcode Substitution

The encoder takes a 32-bit constant and a 4-bit operation code and decides whether the constant fits the compact immediate form. In that form an 8-bit value is rotated right by an even number of bit positions, 2×rot4 with rot4 from 0 to 15. When the constant fits directly, the block returns the 8-bit value, the rotate field and the unchanged operation code.

When the constant does not fit directly and the operation belongs to one of the complementary pairs, the encoder transforms the constant. Add/subtract and compare/compare-negative use two's-complement negation. Add-with-carry/subtract-with-carry, and/bit-clear and move/move-not use bitwise inversion. The encoder then tests the transformed constant. On success it reports the partner operation and the transformed constant's encoding, and raises the substituted flag.

All rotations are tested in parallel in one cycle. The result is registered, so each answer appears one clock after its inputs are sampled.

Top module: `rimm_encoder`

## Requirements
- R1: One clock after a constant is sampled, if some imm8 and rot4 exist for which imm8 rotated right by 2×rot4 within 32 bits equals the constant, the block shows valid=1, that imm8 and rot4, opOut equal to the sampled opcode, and substituted=0.
- R2: When more than one rot4 gives a match, the smallest rot4 is reported.
- R3: The constant 1020 (0x3FC) encodes as imm8=0xFF with rot4=15. The constant 1023 (0x3FF) has no direct encoding.
- R4: Opcode codes are ADD=0, SUB=1, ADC=2, SBC=3, AND=4, BIC=5, MOV=6, MVN=7, CMP=8, CMN=9. For codes 0 to 9 the partner opcode is the code with bit 0 inverted, and substitution reports that partner code on opOut.
- R5: For codes 0, 1, 8 and 9 the transformed constant is the two's-complement negation. For codes 2 to 7 it is the bitwise inverse. A substituted result encodes the transformed constant.
- R6: The direct form always takes priority. substituted=1 only when the partner opcode is reported, and it never occurs together with valid=0.
- R7: When neither form encodes, valid=0 and imm8, rot4, opOut and substituted are all zero.
- R8: Codes 10 to 15 have no partner. For them only the direct form is tried, and substituted stays 0.
- R9: While rstN is low, every output is zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| constIn | input | 32 | Constant to be encoded |
| opIn | input | 4 | Requested operation code |
| valid | output | 1 | An encoding was found |
| imm8 | output | 8 | Unrotated 8-bit value |
| rot4 | output | 4 | Rotate field; rotate right by twice this value |
| opOut | output | 4 | Operation code to use (requested or partner) |
| substituted | output | 1 | Partner opcode and transformed constant were used |

## Verification
The result register is the block's only state, so any fault shows up at the ports in the cycle right after the inputs that caused it. A bad rotation tap or a bad priority order gives a wrong or non-minimal rot4 for constants such as 0xFF000000 or 0xF000000F. A swapped transform mode shows up as a wrong imm8/rot4 pair on constants whose inverse and negation encode differently, such as 0xFFFFFF00 under ADD and under AND. Failures in partner selection or in zeroing show up on opOut or in stale fields when valid is low.

// File: rtl/rimm_pkg.sv
package rimm_pkg;

  localparam int OP_W       = 4;
  localparam int PAIR_CODES = 10;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB = 4'd1;
  localparam logic [OP_W-1:0] OP_CMP = 4'd8;
  localparam logic [OP_W-1:0] OP_CMN = 4'd9;

  // strobes from control to datapath
  typedef struct packed {
    logic pickAlt;  // use transformed constant and partner opcode
    logic accept;   // some encoding exists
  } ctrlStrobe_t;

endpackage

// File: rtl/rimm_rot_search.sv
module rimm_rot_search #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] value,
  output logic              hit,
  output logic [IMM_W-1:0]  imm,
  output logic [ROT_W-1:0]  rot
);
  localparam int ROT_COUNT = DATA_W / 2;

  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rolled [ROT_COUNT];
  logic [ROT_COUNT-1:0] fits;

  assign doubled = {value, value};

  // rolled[r] is value rotated left by 2r; fits when only low IMM_W bits remain
  for (genvar r = 0; r < ROT_COUNT; r++) begin : g_rot
    assign rolled[r] = doubled[2*DATA_W-1-2*r -: DATA_W];
    assign fits[r]   = (rolled[r][DATA_W-1:IMM_W] == '0);
  end

  // lowest matching rotation wins: scan from high to low, last write sticks
  always_comb begin
    hit = 1'b0;
    imm = '0;
    rot = '0;
    for (int r = ROT_COUNT - 1; r >= 0; r--) begin
      if (fits[r]) begin
        hit = 1'b1;
        imm = rolled[r][IMM_W-1:0];
        rot = ROT_W'(r);
      end
    end
  end

endmodule

// File: rtl/rimm_control.sv
module rimm_control
  import rimm_pkg::*;
(
  input  logic [OP_W-1:0] opIn,
  input  logic            directHit,
  input  logic            altHit,
  output logic            negate,
  output ctrlStrobe_t     strobe,
  output logic [OP_W-1:0] finalOp
);
  logic hasPartner;

  assign hasPartner = (opIn < OP_W'(PAIR_CODES));
  assign negate     = (opIn == OP_ADD) || (opIn == OP_SUB) ||
                      (opIn == OP_CMP) || (opIn == OP_CMN);

  always_comb begin
    strobe.pickAlt = !directHit && hasPartner && altHit;
    strobe.accept  = directHit || strobe.pickAlt;
    finalOp        = strobe.pickAlt ? {opIn[OP_W-1:1], ~opIn[0]} : opIn;
  end

endmodule

// File: rtl/rimm_datapath.sv
module rimm_datapath
  import rimm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] constIn,
  input  logic              negate,
  input  ctrlStrobe_t       strobe,
  input  logic [OP_W-1:0]   finalOp,
  output logic              directHit,
  output logic              altHit,
  output logic              valid,
  output logic [IMM_W-1:0]  imm8,
  output logic [ROT_W-1:0]  rot4,
  output logic [OP_W-1:0]   opOut,
  output logic              substituted
);
  localparam int CAND = 2;  // 0: direct, 1: transformed

  logic [DATA_W-1:0] cand    [CAND];
  logic              candHit [CAND];
  logic [IMM_W-1:0]  candImm [CAND];
  logic [ROT_W-1:0]  candRot [CAND];

  assign cand[0] = constIn;
  assign cand[1] = negate ? (~constIn + DATA_W'(1)) : ~constIn;

  for (genvar c = 0; c < CAND; c++) begin : g_cand
    rimm_rot_search #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_search (
      .value (cand[c]),
      .hit   (candHit[c]),
      .imm   (candImm[c]),
      .rot   (candRot[c])
    );
  end

  assign directHit = candHit[0];
  assign altHit    = candHit[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid       <= 1'b0;
      substituted <= 1'b0;
      imm8        <= '0;
      rot4        <= '0;
      opOut       <= '0;
    end else begin
      valid       <= strobe.accept;
      substituted <= strobe.pickAlt;
      imm8        <= !strobe.accept ? '0 : (strobe.pickAlt ? candImm[1] : candImm[0]);
      rot4        <= !strobe.accept ? '0 : (strobe.pickAlt ? candRot[1] : candRot[0]);
      opOut       <= strobe.accept ? finalOp : '0;
    end
  end

  // R7: invalid result carries no stale fields
  p_zero_when_invalid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (imm8 == '0 && rot4 == '0 && opOut == '0 && !substituted));

  // R6: substitution only accompanies a valid result
  p_sub_implies_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    substituted |-> valid);

endmodule

// File: rtl/rimm_encoder.sv
module rimm_encoder
  import rimm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] constIn,
  input  logic [3:0]        opIn,
  output logic              valid,
  output logic [IMM_W-1:0]  imm8,
  output logic [ROT_W-1:0]  rot4,
  output logic [3:0]        opOut,
  output logic              substituted
);
  logic            negate;
  logic            directHit;
  logic            altHit;
  ctrlStrobe_t     strobe;
  logic [OP_W-1:0] finalOp;

  rimm_control u_control (
    .opIn      (opIn),
    .directHit (directHit),
    .altHit    (altHit),
    .negate    (negate),
    .strobe    (strobe),
    .finalOp   (finalOp)
  );

  rimm_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .constIn     (constIn),
    .negate      (negate),
    .strobe      (strobe),
    .finalOp     (finalOp),
    .directHit   (directHit),
    .altHit      (altHit),
    .valid       (valid),
    .imm8        (imm8),
    .rot4        (rot4),
    .opOut       (opOut),
    .substituted (substituted)
  );

  // expand an encoding back into the full-width constant
  function automatic logic [DATA_W-1:0] expandImm(input logic [IMM_W-1:0] v,
                                                   input logic [ROT_W-1:0] r);
    logic [2*DATA_W-1:0] d;
    int sh;
    d  = {2{DATA_W'(v)}};
    sh = 2 * int'(r);
    return d[sh +: DATA_W];
  endfunction

  // R1: a direct result decodes to the sampled constant with its own opcode
  p_direct_decode_r1: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !substituted) |->
      (expandImm(imm8, rot4) == $past(constIn) && opOut == $past(opIn)));

  // R5: a substituted result decodes to the inverse or the negation
  p_alt_decode_r5: assert property (@(posedge clk) disable iff (!rstN)
    substituted |-> (expandImm(imm8, rot4) == ~$past(constIn) ||
                     expandImm(imm8, rot4) == (~$past(constIn) + DATA_W'(1))));

  // R4: substitution reports the pair partner
  p_partner_op_r4: assert property (@(posedge clk) disable iff (!rstN)
    substituted |-> (opOut == ($past(opIn) ^ 4'd1)));

  // R8: codes without a partner are never substituted
  p_no_partner_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opIn) >= 4'd10) |-> !substituted);

endmodule

// File: tb/rimm_encoder_tb.sv
module rimm_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] k;
    logic        v;
    logic [7:0]  imm;
    logic [3:0]  rot;
    logic [3:0]  eop;
    logic        sub;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  32'h000003FC, 1'b1, 8'hFF, 4'd15, 4'd0,  1'b0, 4'd3},  // R3 1020
    '{4'd0,  32'h000003FF, 1'b0, 8'h00, 4'd0,  4'd0,  1'b0, 4'd3},  // R3 1023
    '{4'd6,  32'h000000FF, 1'b1, 8'hFF, 4'd0,  4'd6,  1'b0, 4'd1},  // R1
    '{4'd6,  32'hFF000000, 1'b1, 8'hFF, 4'd4,  4'd6,  1'b0, 4'd2},  // R2
    '{4'd12, 32'hF000000F, 1'b1, 8'hFF, 4'd2,  4'd12, 1'b0, 4'd2},  // R2 wrap
    '{4'd7,  32'hFFFFFF00, 1'b1, 8'hFF, 4'd0,  4'd6,  1'b1, 4'd5},  // R5 MVN->MOV
    '{4'd0,  32'hFFFFFFFF, 1'b1, 8'h01, 4'd0,  4'd1,  1'b1, 4'd5},  // R5 ADD->SUB
    '{4'd8,  32'hFFFFFFFC, 1'b1, 8'h04, 4'd0,  4'd9,  1'b1, 4'd4},  // R4 CMP->CMN
    '{4'd0,  32'hFFFFFF00, 1'b1, 8'h01, 4'd12, 4'd1,  1'b1, 4'd5},  // R5 negation
    '{4'd4,  32'hFFFFFF00, 1'b1, 8'hFF, 4'd0,  4'd5,  1'b1, 4'd5},  // R5 inversion
    '{4'd2,  32'hFFFFFFFE, 1'b1, 8'h01, 4'd0,  4'd3,  1'b1, 4'd4},  // R4 ADC->SBC
    '{4'd1,  32'hFFFFFF01, 1'b1, 8'hFF, 4'd0,  4'd0,  1'b1, 4'd4},  // R4 SUB->ADD
    '{4'd12, 32'hFFFFFFFF, 1'b0, 8'h00, 4'd0,  4'd0,  1'b0, 4'd8},  // R8 no partner
    '{4'd15, 32'h00000005, 1'b1, 8'h05, 4'd0,  4'd15, 1'b0, 4'd8},  // R8 direct
    '{4'd0,  32'h00000000, 1'b1, 8'h00, 4'd0,  4'd0,  1'b0, 4'd6},  // R6 direct first
    '{4'd9,  32'h000000FF, 1'b1, 8'hFF, 4'd0,  4'd9,  1'b0, 4'd6},  // R6
    '{4'd6,  32'h00000104, 1'b1, 8'h41, 4'd15, 4'd6,  1'b0, 4'd1},  // R1
    '{4'd6,  32'h00000102, 1'b0, 8'h00, 4'd0,  4'd0,  1'b0, 4'd7},  // R7 odd shift
    '{4'd3,  32'h3FC00000, 1'b1, 8'hFF, 4'd5,  4'd3,  1'b0, 4'd1}   // R1
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] constIn = '0;
  logic [3:0]  opIn = '0;
  logic        valid;
  logic [7:0]  imm8;
  logic [3:0]  rot4;
  logic [3:0]  opOut;
  logic        substituted;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rimm_encoder u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .constIn     (constIn),
    .opIn        (opIn),
    .valid       (valid),
    .imm8        (imm8),
    .rot4        (rot4),
    .opOut       (opOut),
    .substituted (substituted)
  );

  task automatic checkOut(input string tag, input logic v, input logic [7:0] im,
                          input logic [3:0] ro, input logic [3:0] op, input logic sb);
    checks++;
    if (valid !== v || imm8 !== im || rot4 !== ro || opOut !== op || substituted !== sb) begin
      errors++;
      $display("FAIL %s: got v=%0b imm=%h rot=%0d op=%0d sub=%0b, expected v=%0b imm=%h rot=%0d op=%0d sub=%0b",
               tag, valid, imm8, rot4, opOut, substituted, v, im, ro, op, sb);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    // R9: reset state with live inputs
    constIn = 32'h000000FF;
    opIn    = 4'd6;
    repeat (2) @(negedge clk);
    checkOut("R9 reset", 1'b0, 8'h00, 4'd0, 4'd0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      opIn    = VECS[i].op;
      constIn = VECS[i].k;
      @(negedge clk);
      checkOut($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].v, VECS[i].imm, VECS[i].rot, VECS[i].eop, VECS[i].sub);
    end

    // R7: valid result followed by an unencodable one clears every field
    opIn = 4'd7; constIn = 32'hFFFFFF00;
    @(negedge clk);
    checkOut("R6 setup", 1'b1, 8'hFF, 4'd0, 4'd6, 1'b1);
    opIn = 4'd4; constIn = 32'h00001FE1;
    @(negedge clk);
    checkOut("R7 clear after substitution", 1'b0, 8'h00, 4'd0, 4'd0, 1'b0);

    // R9: asynchronous reset mid-run clears a valid result at once
    opIn = 4'd6; constIn = 32'hFF000000;
    @(negedge clk);
    checkOut("R2 before reset", 1'b1, 8'hFF, 4'd4, 4'd6, 1'b0);
    rstN = 1'b0;
    #1;
    checkOut("R9 async clear", 1'b0, 8'h00, 4'd0, 4'd0, 1'b0);
    @(negedge clk);
    checkOut("R9 held in reset", 1'b0, 8'h00, 4'd0, 4'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b1, 8'hFF, 4'd4, 4'd6, 1'b0);

    done = 1'b1;
    finishRun();
  end

endmodule